// File: doc/BRIEF.md
# Quick DMA Trigger-Word Detector

This block sits beside the configuration-bus write path into a transfer-parameter memory. The memory holds `NUM_ENTRY` entries of `WORDS_PER_ENTRY` 32-bit words each, which is 256 entries of eight words by default. The block keeps `NUM_CHAN` quick channels, eight by default. Each channel holds three settings: an enable, the entry it describes its transfer with, and which word of that entry is its trigger word. Every bus write passes straight through to the memory port, unchanged and in the same cycle.

When a write lands on the trigger word of an enabled channel, the block marks that channel pending. No hardware event is involved. A small arbiter then offers one transfer request at a time to the transfer engine, always choosing the lowest-numbered pending channel. If a channel is triggered again before its earlier request has been accepted, the block raises a sticky missed-trigger flag for that channel.

The arbiter is a two-state machine. In `ARB_IDLE` no request is offered. The PICK transition (any channel pending) moves it to `ARB_OFFER` and latches the chosen channel and entry. In `ARB_OFFER` the HOLD transition (`req_ready` low) keeps the request on the port. The ACCEPT transition (`req_ready` high) retires the request and returns the machine to `ARB_IDLE`.

Top module: `qdma_trig_detect`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `req_valid` is 0, `err_missed` is all zeros and no channel is pending.
- R2: A byte address splits into an entry index in bits [12:5], a word index in bits [4:2] and a byte offset in bits [1:0]. A bus write is a trigger for an enabled channel when the entry index equals the channel's entry, the word index equals the channel's trigger word and the byte offset is 0. `req_valid` rises at the second rising edge after the write cycle, with `req_chan` and `req_entry` naming that channel and entry.
- R3: A write to any other word of a channel's entry, or a write with a nonzero byte offset, produces no request.
- R4: A write to the trigger word of a disabled channel produces no request.
- R5: For every bus write, `ram_wr_en`, `ram_wr_addr` and `ram_wr_data` equal `bus_wr_en`, `bus_wr_addr` and `bus_wr_data` in the same cycle.
- R6: When one write triggers several channels, all of them are offered in turn, in ascending channel order, with channel 0 having the highest priority.
- R7: While `req_valid` is 1 and `req_ready` is 0, `req_valid`, `req_chan` and `req_entry` hold their values at the next edge.
- R8: A trigger for a channel whose previous request has not yet been accepted sets bit `err_missed[ch]`. The flag stays set, and the channel still yields exactly one request.
- R9: A channel-configuration write (`cfg_we` = 1 with `cfg_chan` = ch) clears `err_missed[ch]` at that edge. Nothing else clears it.
- R10: After an accepted request, `req_valid` is 0 for at least one cycle before the next request is offered.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Write one channel's configuration |
| cfg_chan | input | 3 | Channel being configured |
| cfg_enable | input | 1 | New enable for that channel |
| cfg_entry | input | 8 | New parameter entry for that channel |
| cfg_word | input | 3 | New trigger-word index for that channel |
| bus_wr_en | input | 1 | Configuration-bus write strobe |
| bus_wr_addr | input | 13 | Byte address of the bus write |
| bus_wr_data | input | 32 | Bus write data |
| ram_wr_en | output | 1 | Pass-through write strobe to the parameter memory |
| ram_wr_addr | output | 13 | Pass-through byte address |
| ram_wr_data | output | 32 | Pass-through write data |
| req_valid | output | 1 | Transfer request offered |
| req_ready | input | 1 | Transfer engine accepts the offered request |
| req_chan | output | 3 | Channel of the offered request |
| req_entry | output | 8 | Parameter entry of the offered request |
| err_missed | output | 8 | Sticky missed-trigger flag, one bit per channel |

## Verification
The bench builds the block with its default parameters: eight channels, 256 entries and eight words per entry. With these values the outermost corners of the address map can be reached directly. Channel 7 is tested on word 7 of entry 255, the topmost word, and channel 0 on word 0 of entry 0. Four channels share one trigger word so that the full priority ordering is exercised. A scoreboard compares each accepted request against the queue of triggers expected from the requirements, so any missing, extra or out-of-order request is reported.

// File: rtl/qtd_pkg.sv
package qtd_pkg;
    typedef enum logic [0:0] {
        ARB_IDLE  = 1'b0,
        ARB_OFFER = 1'b1
    } arb_state_t;
endpackage

// File: rtl/qtd_chan_regs.sv
module qtd_chan_regs #(
    parameter int NUM_CHAN = 8,
    parameter int ENTRY_W  = 8,
    parameter int WORD_W   = 3,
    localparam int CH_W    = $clog2(NUM_CHAN)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic                              cfg_we,
    input  logic [CH_W-1:0]                   cfg_chan,
    input  logic                              cfg_enable,
    input  logic [ENTRY_W-1:0]                cfg_entry,
    input  logic [WORD_W-1:0]                 cfg_word,
    output logic [NUM_CHAN-1:0]               chan_en,
    output logic [NUM_CHAN-1:0][ENTRY_W-1:0]  chan_entry,
    output logic [NUM_CHAN-1:0][WORD_W-1:0]   chan_word,
    output logic [NUM_CHAN-1:0]               cfg_touch
);
    for (genvar gi = 0; gi < NUM_CHAN; gi++) begin : g_chan
        // One-hot write select for this channel
        assign cfg_touch[gi] = cfg_we && (cfg_chan == CH_W'(gi));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                chan_en[gi]    <= 1'b0;
                chan_entry[gi] <= '0;
                chan_word[gi]  <= '0;
            end else if (cfg_touch[gi]) begin
                chan_en[gi]    <= cfg_enable;
                chan_entry[gi] <= cfg_entry;
                chan_word[gi]  <= cfg_word;
            end
        end
    end
endmodule

// File: rtl/qtd_match.sv
module qtd_match #(
    parameter int NUM_CHAN = 8,
    parameter int ENTRY_W  = 8,
    parameter int WORD_W   = 3,
    localparam int ADDR_W  = ENTRY_W + WORD_W + 2
) (
    input  logic                              bus_wr_en,
    input  logic [ADDR_W-1:0]                 bus_wr_addr,
    input  logic [NUM_CHAN-1:0]               chan_en,
    input  logic [NUM_CHAN-1:0][ENTRY_W-1:0]  chan_entry,
    input  logic [NUM_CHAN-1:0][WORD_W-1:0]   chan_word,
    output logic [NUM_CHAN-1:0]               hit,
    output logic [ENTRY_W-1:0]                wr_entry
);
    logic [WORD_W-1:0] wr_word;
    logic              aligned;

    // Address layout: {entry, word, byte offset}
    assign wr_entry = bus_wr_addr[ADDR_W-1 -: ENTRY_W];
    assign wr_word  = bus_wr_addr[2 +: WORD_W];
    assign aligned  = (bus_wr_addr[1:0] == 2'b00);

    for (genvar gi = 0; gi < NUM_CHAN; gi++) begin : g_cmp
        assign hit[gi] = bus_wr_en && aligned && chan_en[gi]
                       && (chan_entry[gi] == wr_entry)
                       && (chan_word[gi]  == wr_word);
    end
endmodule

// File: rtl/qtd_pend.sv
module qtd_pend #(
    parameter int NUM_CHAN = 8,
    parameter int ENTRY_W  = 8,
    localparam int CH_W    = $clog2(NUM_CHAN)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_CHAN-1:0]               hit,
    input  logic [ENTRY_W-1:0]                wr_entry,
    input  logic                              accept,
    input  logic [CH_W-1:0]                   accept_chan,
    input  logic [NUM_CHAN-1:0]               cfg_touch,
    output logic [NUM_CHAN-1:0]               pending,
    output logic [NUM_CHAN-1:0][ENTRY_W-1:0]  pend_entry,
    output logic [NUM_CHAN-1:0]               err_missed
);
    for (genvar gi = 0; gi < NUM_CHAN; gi++) begin : g_slot
        logic retire;
        logic miss;

        assign retire = accept && (accept_chan == CH_W'(gi));
        // Previous request still outstanding when a new trigger lands
        assign miss   = hit[gi] && pending[gi] && !retire;

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pending[gi]    <= 1'b0;
                pend_entry[gi] <= '0;
                err_missed[gi] <= 1'b0;
            end else begin
                pending[gi]    <= (pending[gi] && !retire) || hit[gi];
                if (hit[gi] && !miss) begin
                    pend_entry[gi] <= wr_entry;
                end
                err_missed[gi] <= (err_missed[gi] && !cfg_touch[gi]) || miss;
            end
        end
    end
endmodule

// File: rtl/qtd_arb.sv
module qtd_arb
    import qtd_pkg::*;
#(
    parameter int NUM_CHAN = 8,
    parameter int ENTRY_W  = 8,
    localparam int CH_W    = $clog2(NUM_CHAN)
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [NUM_CHAN-1:0]               pending,
    input  logic [NUM_CHAN-1:0][ENTRY_W-1:0]  pend_entry,
    input  logic                              req_ready,
    output logic                              req_valid,
    output logic [CH_W-1:0]                   req_chan,
    output logic [ENTRY_W-1:0]                req_entry,
    output logic                              accept,
    output logic [CH_W-1:0]                   accept_chan
);
    arb_state_t       state_q, state_d;
    logic [CH_W-1:0]  pick_chan;
    logic             any_pend;
    logic [CH_W-1:0]  chan_q;
    logic [ENTRY_W-1:0] entry_q;

    // Lowest-numbered pending channel wins
    always_comb begin
        pick_chan = '0;
        for (int i = NUM_CHAN - 1; i >= 0; i--) begin
            if (pending[i]) begin
                pick_chan = CH_W'(i);
            end
        end
    end
    assign any_pend = |pending;

    // Next-state logic: PICK, HOLD, ACCEPT
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_IDLE:  if (any_pend)  state_d = ARB_OFFER;
            ARB_OFFER: if (req_ready) state_d = ARB_IDLE;
            default:                  state_d = ARB_IDLE;
        endcase
    end

    // State register and latched request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_IDLE;
            chan_q  <= '0;
            entry_q <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ARB_IDLE && any_pend) begin
                chan_q  <= pick_chan;
                entry_q <= pend_entry[pick_chan];
            end
        end
    end

    // Outputs
    always_comb begin
        req_valid   = 1'b0;
        accept      = 1'b0;
        unique case (state_q)
            ARB_IDLE:  req_valid = 1'b0;
            ARB_OFFER: begin
                req_valid = 1'b1;
                accept    = req_ready;
            end
            default:   req_valid = 1'b0;
        endcase
        req_chan    = chan_q;
        req_entry   = entry_q;
        accept_chan = chan_q;
    end
endmodule

// File: rtl/qdma_trig_detect.sv
module qdma_trig_detect #(
    parameter int NUM_CHAN        = 8,
    parameter int NUM_ENTRY       = 256,
    parameter int WORDS_PER_ENTRY = 8,
    parameter int DATA_W          = 32,
    localparam int CH_W    = $clog2(NUM_CHAN),
    localparam int ENTRY_W = $clog2(NUM_ENTRY),
    localparam int WORD_W  = $clog2(WORDS_PER_ENTRY),
    localparam int ADDR_W  = ENTRY_W + WORD_W + 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cfg_we,
    input  logic [CH_W-1:0]      cfg_chan,
    input  logic                 cfg_enable,
    input  logic [ENTRY_W-1:0]   cfg_entry,
    input  logic [WORD_W-1:0]    cfg_word,
    input  logic                 bus_wr_en,
    input  logic [ADDR_W-1:0]    bus_wr_addr,
    input  logic [DATA_W-1:0]    bus_wr_data,
    output logic                 ram_wr_en,
    output logic [ADDR_W-1:0]    ram_wr_addr,
    output logic [DATA_W-1:0]    ram_wr_data,
    output logic                 req_valid,
    input  logic                 req_ready,
    output logic [CH_W-1:0]      req_chan,
    output logic [ENTRY_W-1:0]   req_entry,
    output logic [NUM_CHAN-1:0]  err_missed
);
    logic [NUM_CHAN-1:0]               chan_en;
    logic [NUM_CHAN-1:0][ENTRY_W-1:0]  chan_entry;
    logic [NUM_CHAN-1:0][WORD_W-1:0]   chan_word;
    logic [NUM_CHAN-1:0]               cfg_touch;
    logic [NUM_CHAN-1:0]               hit;
    logic [ENTRY_W-1:0]                wr_entry;
    logic [NUM_CHAN-1:0]               pending;
    logic [NUM_CHAN-1:0][ENTRY_W-1:0]  pend_entry;
    logic                              accept;
    logic [CH_W-1:0]                   accept_chan;

    // Writes reach the parameter memory untouched
    assign ram_wr_en   = bus_wr_en;
    assign ram_wr_addr = bus_wr_addr;
    assign ram_wr_data = bus_wr_data;

    qtd_chan_regs #(.NUM_CHAN(NUM_CHAN), .ENTRY_W(ENTRY_W), .WORD_W(WORD_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_chan(cfg_chan),
        .cfg_enable(cfg_enable), .cfg_entry(cfg_entry), .cfg_word(cfg_word),
        .chan_en(chan_en), .chan_entry(chan_entry), .chan_word(chan_word),
        .cfg_touch(cfg_touch)
    );

    qtd_match #(.NUM_CHAN(NUM_CHAN), .ENTRY_W(ENTRY_W), .WORD_W(WORD_W)) u_match (
        .bus_wr_en(bus_wr_en), .bus_wr_addr(bus_wr_addr), .chan_en(chan_en),
        .chan_entry(chan_entry), .chan_word(chan_word), .hit(hit), .wr_entry(wr_entry)
    );

    qtd_pend #(.NUM_CHAN(NUM_CHAN), .ENTRY_W(ENTRY_W)) u_pend (
        .clk(clk), .rst_n(rst_n), .hit(hit), .wr_entry(wr_entry),
        .accept(accept), .accept_chan(accept_chan), .cfg_touch(cfg_touch),
        .pending(pending), .pend_entry(pend_entry), .err_missed(err_missed)
    );

    qtd_arb #(.NUM_CHAN(NUM_CHAN), .ENTRY_W(ENTRY_W)) u_arb (
        .clk(clk), .rst_n(rst_n), .pending(pending), .pend_entry(pend_entry),
        .req_ready(req_ready), .req_valid(req_valid), .req_chan(req_chan),
        .req_entry(req_entry), .accept(accept), .accept_chan(accept_chan)
    );
endmodule

// File: rtl/qtd_checker.sv
module qtd_checker #(
    parameter int NUM_CHAN = 8,
    parameter int CH_W     = 3,
    parameter int ENTRY_W  = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 cfg_we,
    input logic                 req_valid,
    input logic                 req_ready,
    input logic [CH_W-1:0]      req_chan,
    input logic [ENTRY_W-1:0]   req_entry,
    input logic [NUM_CHAN-1:0]  err_missed
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_QUIET: assert (!req_valid && err_missed == '0); // R1
        end
    end

    AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && !req_ready |=> req_valid && $stable(req_chan) && $stable(req_entry)); // R7

    AST_GAP_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && req_ready |=> !req_valid); // R10

    AST_ERR_CLEAR_ONLY_BY_CFG: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(err_missed) & ~err_missed)) |-> $past(cfg_we)); // R9
endmodule

bind qdma_trig_detect qtd_checker #(
    .NUM_CHAN(NUM_CHAN), .CH_W(CH_W), .ENTRY_W(ENTRY_W)
) u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .req_valid(req_valid),
    .req_ready(req_ready), .req_chan(req_chan), .req_entry(req_entry),
    .err_missed(err_missed)
);

// File: tb/tb_qdma_trig_detect.sv
`timescale 1ns/1ps
module tb_qdma_trig_detect;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_chan = '0;
    logic        cfg_enable = 1'b0;
    logic [7:0]  cfg_entry = '0;
    logic [2:0]  cfg_word = '0;
    logic        bus_wr_en = 1'b0;
    logic [12:0] bus_wr_addr = '0;
    logic [31:0] bus_wr_data = '0;
    logic        ram_wr_en;
    logic [12:0] ram_wr_addr;
    logic [31:0] ram_wr_data;
    logic        req_valid;
    logic        req_ready = 1'b1;
    logic [2:0]  req_chan;
    logic [7:0]  req_entry;
    logic [7:0]  err_missed;

    int n_tests = 0;
    int n_fail  = 0;
    logic [10:0] exp_q[$];

    always #2 clk = ~clk;

    qdma_trig_detect dut (.*);

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cfg(input int ch, input bit en, input int entry, input int word);
        @(negedge clk);
        cfg_we = 1'b1; cfg_chan = 3'(ch); cfg_enable = en;
        cfg_entry = 8'(entry); cfg_word = 3'(word);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // Drives one write and checks the pass-through (R5) in the same cycle
    task automatic bus_write(input logic [12:0] addr, input logic [31:0] data);
        @(negedge clk);
        bus_wr_en = 1'b1; bus_wr_addr = addr; bus_wr_data = data;
        #1;
        check(ram_wr_en && ram_wr_addr == addr && ram_wr_data == data, "R5 pass-through",
              int'(ram_wr_addr), int'(addr));
        @(negedge clk);
        bus_wr_en = 1'b0;
    endtask

    task automatic expect_req(input int ch, input int entry);
        exp_q.push_back({3'(ch), 8'(entry)});
    endtask

    function automatic logic [12:0] a_of(input int entry, input int word);
        return {8'(entry), 3'(word), 2'b00};
    endfunction

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor: every accepted request must match the scoreboard head (R6)
    always @(negedge clk) begin
        #1;
        if (rst_n && req_valid && req_ready) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R3/R4 unexpected request", int'({req_chan, req_entry}), 0);
            end else begin
                logic [10:0] e;
                e = exp_q.pop_front();
                check({req_chan, req_entry} == e, "R6 request order/content",
                      int'({req_chan, req_entry}), int'(e));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (100000) @(posedge clk);
        check(1'b0, "watchdog expired", 0, 1);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        #1;
        check(!req_valid && err_missed == 0, "R1 reset state", int'(req_valid), 0);
        @(negedge clk); rst_n = 1'b1;
        #1;
        check(!req_valid && err_missed == 0, "R1 after release", int'(err_missed), 0);

        // R2: single trigger with latency check
        cfg(2, 1'b1, 8'h33, 5);
        expect_req(2, 8'h33);
        bus_write(a_of(8'h33, 5), 32'hA5A5_0001);
        #1;
        check(!req_valid, "R2 no request after first edge", int'(req_valid), 0);
        @(negedge clk); #1;
        check(req_valid && req_chan == 2 && req_entry == 8'h33, "R2 request at second edge",
              int'({req_chan, req_entry}), int'({3'd2, 8'h33}));
        idle(3);

        // R3: other words of the entry, and a misaligned write
        bus_write(a_of(8'h33, 4), 32'h1);
        bus_write(a_of(8'h33, 6), 32'h2);
        bus_write(a_of(8'h33, 5) | 13'd2, 32'h3);
        idle(4); #1;
        check(!req_valid && exp_q.size() == 0, "R3 non-trigger word", int'(req_valid), 0);

        // R4: disabled channel
        cfg(2, 1'b0, 8'h33, 5);
        bus_write(a_of(8'h33, 5), 32'h4);
        idle(4); #1;
        check(!req_valid, "R4 disabled channel", int'(req_valid), 0);

        // R2 boundary: topmost word of the last entry on channel 7, first word of entry 0 on channel 0
        cfg(7, 1'b1, 255, 7);
        expect_req(7, 255);
        bus_write(a_of(255, 7), 32'hFFFF_FFFF);
        idle(4);
        cfg(0, 1'b1, 0, 0);
        expect_req(0, 0);
        bus_write(a_of(0, 0), 32'h0);
        idle(4); #1;
        check(exp_q.size() == 0, "R2 corner addresses served", exp_q.size(), 0);

        // R6 and R10: one write triggers channels 1,3,5,6
        cfg(0, 1'b0, 0, 0);
        cfg(7, 1'b0, 0, 0);
        cfg(1, 1'b1, 10, 4);
        cfg(3, 1'b1, 10, 4);
        cfg(5, 1'b1, 10, 4);
        cfg(6, 1'b1, 10, 4);
        expect_req(1, 10); expect_req(3, 10); expect_req(5, 10); expect_req(6, 10);
        bus_write(a_of(10, 4), 32'hCAFE);
        @(negedge clk); #1;
        check(req_valid && req_chan == 1, "R6 lowest channel first", int'(req_chan), 1);
        @(negedge clk); #1;
        check(!req_valid, "R10 gap after accept", int'(req_valid), 0);
        idle(8); #1;
        check(exp_q.size() == 0, "R6 all queued channels served", exp_q.size(), 0);

        // R7 and R8: hold while not ready, retrigger while outstanding
        cfg(4, 1'b1, 20, 1);
        req_ready = 1'b0;
        expect_req(4, 20);
        bus_write(a_of(20, 1), 32'h11);
        idle(4); #1;
        check(req_valid && req_chan == 4 && req_entry == 20, "R7 request held",
              int'({req_chan, req_entry}), int'({3'd4, 8'd20}));
        bus_write(a_of(20, 1), 32'h22);
        #1;
        check(err_missed == 8'h10, "R8 missed-trigger flag", int'(err_missed), 8'h10);
        idle(3); #1;
        check(req_valid && req_chan == 4, "R7 still held", int'(req_chan), 4);
        req_ready = 1'b1;
        idle(6); #1;
        check(exp_q.size() == 0 && !req_valid, "R8 single request", exp_q.size(), 0);
        check(err_missed == 8'h10, "R8 flag sticky", int'(err_missed), 8'h10);

        // R9: reconfiguring the channel clears its flag
        cfg(4, 1'b1, 20, 1);
        #1;
        check(err_missed == 8'h00, "R9 flag cleared by cfg", int'(err_missed), 0);

        idle(4);
        check(exp_q.size() == 0, "R6 scoreboard empty", exp_q.size(), 0);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule